// File: doc/BRIEF.md
# Serial Register Port

This block is the slave side of a four-wire serial register port for a data converter. A host frames each transfer by pulling a frame-select line low and toggling a serial clock. Every transfer is a full-duplex 16-bit frame. On the way in, the top two bits of the frame name a destination register and the lower fourteen bits are its new contents. On the way out, the block shifts a 16-bit word taken from a source that the host picked earlier, through two bits of the control register.

Incoming data is committed only when the sixteenth bit has arrived, so a frame that is cut short changes nothing. The outgoing word is fixed when the frame begins. This means a control write that changes the read source takes effect from the next frame onward. A polarity input chooses which clock edge samples the input. A coding input chooses whether the conversion result is sent as straight binary or as two's complement. The serial clock and frame-select are sampled in the system clock domain, so the system clock must run several times faster than the serial clock.

Top module: `serial_reg_port`

## Requirements
- R1: Frame bits 15:14 are the address. Address 11 writes bits 13:0 to the control register and address 01 writes them to the calibration register. Addresses 00 and 10 write nothing.
- R2: A write is committed on the active edge that carries bit 0 (the sixteenth bit). If frame-select rises before that edge, nothing is written.
- R3: The control register is 14 bits, resets to zero and is visible on `ctrlOut`. The calibration register is 14 bits, resets to zero and is visible on `calOut`.
- R4: Control bits 7:6 pick the read source: 00 the conversion result, 11 the status word, 10 the calibration register, 01 all zeros. The choice stays in force for every later frame until the control register is written again. The word is taken when frame-select falls.
- R5: A conversion-result word is four zero bits followed by the 12-bit result, sent MSB first.
- R6: When `bipolar` is high, the result is sent as two's complement, which means its MSB is inverted. When `bipolar` is low, it is sent as straight binary.
- R7: A calibration read is two zero bits followed by the 14 stored bits.
- R8: When `polarity` is high, a rising `sclk` edge samples `din` and a falling edge moves `dout` to the next bit. When `polarity` is low, the roles of the two edges are swapped.
- R9: `dout` is low while `syncN` is high. Bit 15 of the read word appears on `dout` one clock after `syncN` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock from the host |
| syncN | input | 1 | Active-low frame select |
| din | input | 1 | Serial data in, MSB first |
| polarity | input | 1 | Selects the active serial clock edge |
| bipolar | input | 1 | Selects two's complement coding of the result |
| convResult | input | 12 | Latest conversion result, straight binary |
| statusWord | input | 16 | Status word offered for reads |
| dout | output | 1 | Serial data out, MSB first |
| ctrlOut | output | 14 | Control register contents |
| calOut | output | 14 | Calibration register contents |

## Verification
A bit counter that is off by one shows up in two ways. A full frame fails to land in `ctrlOut` or `calOut`, or a short frame lands when it should not, and either is visible a few clocks after frame-select rises. A stale or wrong read-select value corrupts every bit of the next frame's `dout` word from its very first bit. An inverted edge selection shifts the read word by one bit, which can be seen within the first two serial clocks.

// File: rtl/serial_reg_port_pkg.sv
package serial_reg_port_pkg;
  typedef struct packed {
    logic load;     // frame opened: take the read word
    logic capture;  // active edge: sample din
    logic commit;   // final bit sampled: write the register
    logic advance;  // idle edge: present the next output bit
    logic drive;    // frame in progress
  } strobeT;

  localparam logic [1:0] ADDR_CTRL = 2'b11;
  localparam logic [1:0] ADDR_CAL  = 2'b01;
  localparam logic [1:0] SEL_RESULT = 2'b00;
  localparam logic [1:0] SEL_STATUS = 2'b11;
  localparam logic [1:0] SEL_CAL    = 2'b10;
endpackage

// File: rtl/serial_reg_port_ctrl.sv
module serial_reg_port_ctrl
  import serial_reg_port_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclk,
  input  logic   syncN,
  input  logic   polarity,
  output strobeT strobe
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic sclkPrev;
  logic syncPrev;
  logic [CNT_W-1:0] bitCnt;
  logic riseEdge, fallEdge, activeEdge, idleEdge, frameStart, inFrame;

  assign riseEdge   = sclk & ~sclkPrev;
  assign fallEdge   = ~sclk & sclkPrev;
  assign activeEdge = polarity ? riseEdge : fallEdge;
  assign idleEdge   = polarity ? fallEdge : riseEdge;
  assign inFrame    = ~syncN;
  assign frameStart = ~syncN & syncPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      syncPrev <= 1'b1;
      bitCnt   <= '0;
    end else begin
      sclkPrev <= sclk;
      syncPrev <= syncN;
      if (!inFrame || frameStart)
        bitCnt <= '0;
      else if (activeEdge && bitCnt < FULL)
        bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.drive   = inFrame;
    strobe.load    = frameStart;
    strobe.capture = inFrame & ~frameStart & activeEdge & (bitCnt < FULL);
    strobe.commit  = strobe.capture & (bitCnt == LAST);
    strobe.advance = inFrame & ~frameStart & idleEdge & (bitCnt != '0) & (bitCnt < FULL);
  end
endmodule

// File: rtl/serial_reg_port_data.sv
module serial_reg_port_data
  import serial_reg_port_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int RES_W   = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strobe,
  input  logic               din,
  input  logic               bipolar,
  input  logic [RES_W-1:0]   convResult,
  input  logic [FRAME_W-1:0] statusWord,
  output logic               dout,
  output logic [FRAME_W-3:0] ctrlOut,
  output logic [FRAME_W-3:0] calOut
);
  localparam int DATA_W = FRAME_W - 2;
  localparam int RES_PAD = FRAME_W - RES_W;

  logic [FRAME_W-1:0] rxShift;
  logic [FRAME_W-1:0] txShift;
  logic [FRAME_W-1:0] fullFrame;
  logic [FRAME_W-1:0] readWord;
  logic [RES_W-1:0]   codedResult;
  logic [1:0]         readSel;

  assign fullFrame   = {rxShift[FRAME_W-2:0], din};
  assign readSel     = ctrlOut[7:6];
  assign codedResult = bipolar ? {~convResult[RES_W-1], convResult[RES_W-2:0]} : convResult;

  always_comb begin
    case (readSel)
      SEL_RESULT: readWord = {{RES_PAD{1'b0}}, codedResult};
      SEL_STATUS: readWord = statusWord;
      SEL_CAL:    readWord = {2'b00, calOut};
      default:    readWord = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      ctrlOut <= '0;
      calOut  <= '0;
    end else begin
      if (strobe.capture) rxShift <= fullFrame;
      if (strobe.load)
        txShift <= readWord;
      else if (strobe.advance)
        txShift <= {txShift[FRAME_W-2:0], 1'b0};
      if (strobe.commit) begin
        if (fullFrame[FRAME_W-1 -: 2] == ADDR_CTRL) ctrlOut <= fullFrame[DATA_W-1:0];
        if (fullFrame[FRAME_W-1 -: 2] == ADDR_CAL)  calOut  <= fullFrame[DATA_W-1:0];
      end
    end
  end

  assign dout = strobe.drive & txShift[FRAME_W-1];
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import serial_reg_port_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int RES_W   = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclk,
  input  logic               syncN,
  input  logic               din,
  input  logic               polarity,
  input  logic               bipolar,
  input  logic [RES_W-1:0]   convResult,
  input  logic [FRAME_W-1:0] statusWord,
  output logic               dout,
  output logic [FRAME_W-3:0] ctrlOut,
  output logic [FRAME_W-3:0] calOut
);
  strobeT strobe;

  serial_reg_port_ctrl #(.FRAME_W(FRAME_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .syncN(syncN),
    .polarity(polarity), .strobe(strobe)
  );

  serial_reg_port_data #(.FRAME_W(FRAME_W), .RES_W(RES_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .din(din), .bipolar(bipolar),
    .convResult(convResult), .statusWord(statusWord), .dout(dout),
    .ctrlOut(ctrlOut), .calOut(calOut)
  );
endmodule

// File: rtl/serial_reg_port_chk.sv
module serial_reg_port_chk #(
  parameter int FRAME_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               syncN,
  input logic               dout,
  input logic [FRAME_W-3:0] ctrlOut,
  input logic [FRAME_W-3:0] calOut
);
  // R9: no data is driven outside a frame
  a_r9_quiet_outside_frame: assert property (@(posedge clk) disable iff (!rstN)
    syncN |-> !dout);

  // R2: the control register cannot change while no frame is open
  a_r2_ctrl_held_idle: assert property (@(posedge clk) disable iff (!rstN)
    syncN |=> $stable(ctrlOut));

  // R2: the calibration register cannot change while no frame is open
  a_r2_cal_held_idle: assert property (@(posedge clk) disable iff (!rstN)
    syncN |=> $stable(calOut));

  // R3: registers come out of reset cleared
  a_r3_reset_clear: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (ctrlOut == '0 && calOut == '0));
endmodule

bind serial_reg_port serial_reg_port_chk #(.FRAME_W(FRAME_W)) uChk (
  .clk(clk), .rstN(rstN), .syncN(syncN), .dout(dout),
  .ctrlOut(ctrlOut), .calOut(calOut)
);

// File: tb/serial_reg_port_test.sv
module serial_reg_port_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic syncN = 1'b1;
  logic din = 1'b0;
  logic polarity = 1'b1;
  logic bipolar = 1'b0;
  logic [11:0] convResult = '0;
  logic [15:0] statusWord = '0;
  logic dout;
  logic [13:0] ctrlOut, calOut;
  int total = 0;
  int bad = 0;
  logic [15:0] rd;

  always #10 clk = ~clk;

  serial_reg_port uut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .syncN(syncN), .din(din),
    .polarity(polarity), .bipolar(bipolar), .convResult(convResult),
    .statusWord(statusWord), .dout(dout), .ctrlOut(ctrlOut), .calOut(calOut)
  );

  // conv, status, bipolar, polarity, write word, expected read, expected ctrl
  typedef struct packed {
    logic [11:0] conv;
    logic [15:0] stat;
    logic        bip;
    logic        pol;
    logic [15:0] wr;
    logic [15:0] expRd;
    logic [13:0] expCtrl;
  } vecT;

  localparam vecT VECS [10] = '{
    '{12'hABC, 16'h0000, 1'b0, 1'b1, 16'h0000, 16'h0ABC, 14'h0000}, // R5 R1 ignored addr
    '{12'hABC, 16'h0000, 1'b1, 1'b1, 16'hC0C0, 16'h02BC, 14'h00C0}, // R6 R1 ctrl write
    '{12'hABC, 16'h5A3C, 1'b0, 1'b0, 16'h4123, 16'h5A3C, 14'h00C0}, // R4 R8 status
    '{12'hABC, 16'h5A3C, 1'b0, 1'b0, 16'hC080, 16'h5A3C, 14'h0080}, // R4 persists
    '{12'hABC, 16'h5A3C, 1'b0, 1'b1, 16'h0000, 16'h0123, 14'h0080}, // R7 cal read
    '{12'hABC, 16'h5A3C, 1'b0, 1'b1, 16'hC040, 16'h0123, 14'h0040}, // R4
    '{12'hABC, 16'h5A3C, 1'b0, 1'b1, 16'h8FFF, 16'h0000, 14'h0040}, // R4 zeros, R1 addr 10
    '{12'hABC, 16'h5A3C, 1'b0, 1'b1, 16'hC000, 16'h0000, 14'h0000}, // R1
    '{12'h000, 16'h0000, 1'b1, 1'b1, 16'h0000, 16'h0800, 14'h0000}, // R6 zero code
    '{12'hFFF, 16'h0000, 1'b0, 1'b0, 16'h0000, 16'h0FFF, 14'h0000}  // R5 R8 full scale
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Runs a frame of nBits bits; rdOut holds the bits seen on dout
  task automatic frame(input logic [15:0] w, input int nBits, output logic [15:0] rdOut);
    rdOut = '0;
    sclk = polarity ? 1'b0 : 1'b1;
    waitClk(2);
    syncN = 1'b0;
    waitClk(2);
    for (int i = 0; i < nBits; i++) begin
      rdOut[15-i] = dout;
      din = w[15-i];
      waitClk(1);
      sclk = ~sclk;
      waitClk(2);
      sclk = ~sclk;
      waitClk(2);
    end
    syncN = 1'b1;
    waitClk(2);
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    waitClk(3);
    rstN = 1'b1;
    waitClk(2);
    check("R3 ctrl reset", {2'b0, ctrlOut}, 16'h0000);
    check("R3 cal reset", {2'b0, calOut}, 16'h0000);
    check("R9 dout idle", {15'b0, dout}, 16'h0000);

    for (int k = 0; k < 10; k++) begin
      convResult = VECS[k].conv;
      statusWord = VECS[k].stat;
      bipolar    = VECS[k].bip;
      polarity   = VECS[k].pol;
      frame(VECS[k].wr, 16, rd);
      check($sformatf("R4 R5 R8 read vec %0d", k), rd, VECS[k].expRd);
      check($sformatf("R1 ctrl vec %0d", k), {2'b0, ctrlOut}, {2'b0, VECS[k].expCtrl});
    end
    check("R1 cal written by addr 01", {2'b0, calOut}, 16'h0123);

    // R2: aborted frames write nothing
    polarity = 1'b1;
    frame(16'hC0C0, 8, rd);
    check("R2 abort after 8 bits", {2'b0, ctrlOut}, 16'h0000);
    frame(16'h7FFF, 15, rd);
    check("R2 abort after 15 bits", {2'b0, calOut}, 16'h0123);
    convResult = 12'h321;
    bipolar = 1'b0;
    frame(16'h0000, 16, rd);
    check("R2 R4 select unchanged after abort", rd, 16'h0321);

    // R7: full 14-bit calibration content with two leading zeros
    frame(16'h7FFF, 16, rd);
    check("R1 cal all ones", {2'b0, calOut}, 16'h3FFF);
    frame(16'hC080, 16, rd);
    frame(16'h0000, 16, rd);
    check("R7 cal read leading zeros", rd, 16'h3FFF);

    // R9: first bit appears one clock after frame opens
    frame(16'hC0C0, 16, rd);
    statusWord = 16'h8001;
    syncN = 1'b0;
    waitClk(2);
    check("R9 first bit present", {15'b0, dout}, 16'h0001);
    syncN = 1'b1;
    waitClk(2);
    check("R9 dout low after abort", {15'b0, dout}, 16'h0000);

    // R3: reset clears registers
    rstN = 1'b0;
    waitClk(2);
    rstN = 1'b1;
    waitClk(1);
    check("R3 ctrl cleared", {2'b0, ctrlOut}, 16'h0000);
    check("R3 cal cleared", {2'b0, calOut}, 16'h0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule